// File: doc/BRIEF.md
# Virtual Output Queued Cell Switch

This block is a small cell switch with a fixed number of ports. Every input holds a separate queue for each output, so a cell whose output is congested waits in its own queue and does not hold back cells that are heading elsewhere. Each input offers one fixed-size cell per cycle, tagged with its destination port, through a valid/ready handshake. A cell offered to a full queue is refused, never dropped.

In every cycle a single-pass request/grant/accept matcher with round-robin pointers picks a set of input-output pairs in which no input and no output appears twice. A crossbar then moves every chosen cell, whole, into a small buffer at its output. An output with a full buffer withdraws from matching, which acts as backpressure. Each output drains through its own valid/ready handshake.

Top module: `vqs_switch`

## Requirements
- R1: A cell queued for an output that cannot accept it never delays a cell from the same input to a different output. The second cell still reaches its output with the minimum latency.
- R2: In any cycle, each input sends at most one cell and each output receives at most one cell.
- R3: A cell is accepted at the clock edge where `in_valid` and `in_ready` are both high. It is routed to the output given by its `in_dest` field (a binary port index). When the path is uncontested and the output buffer is empty, the cell appears unchanged on `out_cell` with `out_valid` high after the following edge.
- R4: No cell is moved into a full output buffer. Every accepted cell is delivered exactly once.
- R5: For each input, `in_ready` is low exactly when the queue selected by the offered `in_dest` is full. A refused cell is not stored.
- R6: Cells from one input to one output leave in the order in which they were accepted.
- R7: An input requests an output only when its queue for that output holds a cell and that output's buffer is not full. Round-robin pointers advance only on an accepted grant. When every input holds one cell for the same output, that output delivers all of them on consecutive cycles, one from each input.
- R8: When the waiting cells form a permutation (every input bound to a distinct output), all of them cross the crossbar in the same cycle.
- R9: After reset, every `out_valid` is low and every `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N_PORTS | Per-input cell offer |
| in_ready | output | N_PORTS | Per-input acceptance (queue for offered destination not full) |
| in_dest | input | N_PORTS*PW | Destination index per input, PW bits each |
| in_cell | input | N_PORTS*CELL_W | Cell payload per input, CELL_WORDS words of WORD_W bits |
| out_valid | output | N_PORTS | Output buffer holds a cell |
| out_ready | input | N_PORTS | Downstream takes the presented cell |
| out_cell | output | N_PORTS*CELL_W | Cell at the head of each output buffer |

## Verification
A cell accepted at edge k crosses the crossbar at edge k+1 if it wins matching. It is then visible at its output right after that edge. Refusal shows on `in_ready` in the same cycle as the offer, because it is combinational. The bench drives inputs shortly after a rising edge, reads `in_ready` one nanosecond later, and checks outputs after a counted number of edges. Under contention, one cell is due on each of the following consecutive cycles. A falling-edge monitor checks every delivered cell's contents, its destination and its per-pair sequence number against counters that the bench keeps from its own offers.

// File: rtl/vqs_pkg.sv
// Package: defaults and helpers shared by the switch modules.
// Assumes: indices are small non-negative integers.
package vqs_pkg;

    parameter int unsigned DEF_PORTS      = 4;
    parameter int unsigned DEF_CELL_WORDS = 4;
    parameter int unsigned DEF_WORD_W     = 32;
    parameter int unsigned DEF_VOQ_DEPTH  = 4;
    parameter int unsigned DEF_OBUF_DEPTH = 4;

    // Successor of a round-robin position, wrapping at n.
    function automatic int unsigned rr_next(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/vqs_fifo.sv
// Module: vqs_fifo
// A synchronous FIFO with the head word visible on rdata whenever it is
// not empty. It is used both for the per-input virtual queues and for the
// output buffers.
// Assumes: the caller does not push while full or pop while empty; both
// are also guarded internally.
module vqs_fifo #(
    parameter int unsigned W     = 128,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;
    logic [CW-1:0] count;
    logic          do_push;
    logic          do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (full && !pop) |=> full); // R4

endmodule

// File: rtl/vqs_rr_arb.sv
// Module: vqs_rr_arb
// A round-robin priority picker. The search starts at ptr and returns the
// first active request as a one-hot grant, together with its index.
// Assumes: ptr < N.
module vqs_rr_arb #(
    parameter int unsigned N  = 4,
    parameter int unsigned PW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [PW-1:0] idx
);
    // Rotating first-one search from the pointer.
    always_comb begin : pick
        int unsigned pos;
        logic        found;
        gnt   = '0;
        idx   = '0;
        found = 1'b0;
        pos   = 0;
        for (int unsigned k = 0; k < N; k++) begin
            pos = (32'(ptr) + k) % N;
            if (!found && req[pos]) begin
                gnt[pos] = 1'b1;
                idx      = PW'(pos);
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vqs_matcher.sv
// Module: vqs_matcher
// A single-iteration request/grant/accept matcher. Each output grants one
// requesting input, round-robin from its grant pointer. Each input accepts
// one of the grants it received, round-robin from its accept pointer. A
// pointer moves one place past its winner only when the grant is accepted.
// Assumes: req[i*N+j] means input i wants output j.
module vqs_matcher #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N*N-1:0] req,
    output logic [N*N-1:0] match
);
    import vqs_pkg::*;

    localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0][N-1:0] col_req;   // [output][input]
    logic [N-1:0][N-1:0] gnt_out;   // [output][input]
    logic [N-1:0][N-1:0] gnt_in;    // [input][output]
    logic [N-1:0][N-1:0] acc;       // [input][output]
    logic [N-1:0][N-1:0] col_match; // [output][input]
    logic [PW-1:0]       g_ptr [N];
    logic [PW-1:0]       a_ptr [N];
    logic [PW-1:0]       g_idx [N];
    logic [PW-1:0]       a_idx [N];

    // Regroup requests by output for the grant stage.
    always_comb begin
        for (int unsigned j = 0; j < N; j++)
            for (int unsigned i = 0; i < N; i++)
                col_req[j][i] = req[i*N + j];
    end

    // Regroup grants by input for the accept stage.
    always_comb begin
        for (int unsigned i = 0; i < N; i++)
            for (int unsigned j = 0; j < N; j++)
                gnt_in[i][j] = gnt_out[j][i];
    end

    // Flatten the accepted pairs and regroup them by output.
    always_comb begin
        for (int unsigned i = 0; i < N; i++)
            for (int unsigned j = 0; j < N; j++) begin
                match[i*N + j]  = acc[i][j];
                col_match[j][i] = acc[i][j];
            end
    end

    for (genvar j = 0; j < N; j++) begin : g_grant
        vqs_rr_arb #(.N(N), .PW(PW)) grant_arb_i (
            .req (col_req[j]),
            .ptr (g_ptr[j]),
            .gnt (gnt_out[j]),
            .idx (g_idx[j])
        );

        // Grant pointer moves past the winner only when it accepted.
        always_ff @(posedge clk) begin
            if (!rst_n)            g_ptr[j] <= '0;
            else if (|col_match[j]) g_ptr[j] <= PW'(rr_next(32'(g_idx[j]), N));
        end

        AST_OUTPUT_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(col_match[j])); // R2
        AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gnt_out[j] & ~col_req[j]) == '0); // R7
    end

    for (genvar i = 0; i < N; i++) begin : g_accept
        vqs_rr_arb #(.N(N), .PW(PW)) accept_arb_i (
            .req (gnt_in[i]),
            .ptr (a_ptr[i]),
            .gnt (acc[i]),
            .idx (a_idx[i])
        );

        // Accept pointer moves past the accepted output.
        always_ff @(posedge clk) begin
            if (!rst_n)      a_ptr[i] <= '0;
            else if (|acc[i]) a_ptr[i] <= PW'(rr_next(32'(a_idx[i]), N));
        end

        AST_INPUT_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(acc[i])); // R2
    end

    AST_MATCH_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (match & ~req) == '0); // R7

endmodule

// File: rtl/vqs_switch.sv
// Module: vqs_switch (top)
// An N-port cell switch. Each input holds one queue per output, a matcher
// picks disjoint input-output pairs every cycle, a crossbar carries each
// chosen cell whole, and a small buffer at each output drains downstream.
// An output whose buffer is full is left out of matching (backpressure).
// Assumes: in_dest is a binary port index below N_PORTS.
module vqs_switch #(
    parameter int unsigned N_PORTS    = vqs_pkg::DEF_PORTS,
    parameter int unsigned CELL_WORDS = vqs_pkg::DEF_CELL_WORDS,
    parameter int unsigned WORD_W     = vqs_pkg::DEF_WORD_W,
    parameter int unsigned VOQ_DEPTH  = vqs_pkg::DEF_VOQ_DEPTH,
    parameter int unsigned OBUF_DEPTH = vqs_pkg::DEF_OBUF_DEPTH,
    localparam int unsigned PW        = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
    localparam int unsigned CELL_W    = CELL_WORDS * WORD_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          in_valid,
    output logic [N_PORTS-1:0]          in_ready,
    input  logic [N_PORTS*PW-1:0]       in_dest,
    input  logic [N_PORTS*CELL_W-1:0]   in_cell,
    output logic [N_PORTS-1:0]          out_valid,
    input  logic [N_PORTS-1:0]          out_ready,
    output logic [N_PORTS*CELL_W-1:0]   out_cell
);
    localparam int unsigned NN = N_PORTS * N_PORTS;

    logic [NN-1:0]       voq_full;
    logic [NN-1:0]       voq_empty;
    logic [CELL_W-1:0]   voq_rdata [NN];
    logic [NN-1:0]       req;
    logic [NN-1:0]       match;
    logic [N_PORTS-1:0]  ob_full;
    logic [N_PORTS-1:0]  ob_empty;
    logic [N_PORTS-1:0]  xb_push;
    logic [CELL_W-1:0]   xb_data [N_PORTS];

    // Ready follows the fill state of the queue the offered cell targets.
    always_comb begin
        for (int unsigned i = 0; i < N_PORTS; i++)
            in_ready[i] = !voq_full[i*N_PORTS + 32'(in_dest[i*PW +: PW])];
    end

    // Request only with a waiting cell and room at the output.
    always_comb begin
        for (int unsigned i = 0; i < N_PORTS; i++)
            for (int unsigned j = 0; j < N_PORTS; j++)
                req[i*N_PORTS + j] = !voq_empty[i*N_PORTS + j] && !ob_full[j];
    end

    for (genvar i = 0; i < N_PORTS; i++) begin : g_in
        for (genvar j = 0; j < N_PORTS; j++) begin : g_voq
            logic voq_push;
            assign voq_push = in_valid[i] && (in_dest[i*PW +: PW] == PW'(j))
                              && !voq_full[i*N_PORTS + j];

            vqs_fifo #(.W(CELL_W), .DEPTH(VOQ_DEPTH)) voq_i (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (voq_push),
                .wdata (in_cell[i*CELL_W +: CELL_W]),
                .pop   (match[i*N_PORTS + j]),
                .rdata (voq_rdata[i*N_PORTS + j]),
                .empty (voq_empty[i*N_PORTS + j]),
                .full  (voq_full[i*N_PORTS + j])
            );
        end
    end

    vqs_matcher #(.N(N_PORTS)) matcher_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .match (match)
    );

    // Crossbar: each output gathers the cell of its matched input.
    always_comb begin
        for (int unsigned j = 0; j < N_PORTS; j++) begin
            xb_data[j] = '0;
            xb_push[j] = 1'b0;
            for (int unsigned i = 0; i < N_PORTS; i++) begin
                if (match[i*N_PORTS + j]) begin
                    xb_data[j] = xb_data[j] | voq_rdata[i*N_PORTS + j];
                    xb_push[j] = 1'b1;
                end
            end
        end
    end

    for (genvar j = 0; j < N_PORTS; j++) begin : g_out
        vqs_fifo #(.W(CELL_W), .DEPTH(OBUF_DEPTH)) obuf_i (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (xb_push[j]),
            .wdata (xb_data[j]),
            .pop   (out_valid[j] && out_ready[j]),
            .rdata (out_cell[j*CELL_W +: CELL_W]),
            .empty (ob_empty[j]),
            .full  (ob_full[j])
        );

        assign out_valid[j] = !ob_empty[j];

        AST_OBUF_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n) xb_push[j] |-> !ob_full[j]); // R4
    end

    AST_RESET_IDLE: assert property (@(posedge clk) $past(!rst_n) |-> (out_valid == '0)); // R9

endmodule

// File: tb/vqs_switch_tb.sv
// Bench for vqs_switch: directed sweeps over every pair, permutations,
// single-output contention and a stalled output, then random traffic. A
// falling-edge monitor checks each delivered cell.
module vqs_switch_tb_top;
    localparam int N  = 4;
    localparam int PW = 2;
    localparam int CW = 128;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N-1:0]    in_ready;
    logic [N*PW-1:0] in_dest = '0;
    logic [N*CW-1:0] in_cell = '0;
    logic [N-1:0]    out_valid;
    logic [N-1:0]    out_ready = '1;
    logic [N*CW-1:0] out_cell;

    int errors = 0;
    int checks = 0;
    int tx_seq [N][N];
    int rx_seq [N][N];
    int tx_total = 0;
    int rx_total = 0;
    logic [N-1:0] seen_src [N];
    logic [N-1:0] vsel = '0;
    int dsel [N];
    logic [N-1:0] acc_mask;

    always #4 clk = ~clk;

    vqs_switch dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dest(in_dest), .in_cell(in_cell), .out_valid(out_valid),
        .out_ready(out_ready), .out_cell(out_cell)
    );

    function automatic logic [CW-1:0] make_cell(int src, int dst, int seq);
        logic [CW-1:0] c;
        for (int w = 0; w < 4; w++)
            c[w*32 +: 32] = {(w == 0) ? 8'hC0 : 8'(w), 8'(src), 8'(dst), 8'(seq)};
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Drive the offers in vsel/dsel and note which ones are taken at the next edge.
    task automatic apply();
        for (int s = 0; s < N; s++) begin
            in_valid[s] = vsel[s];
            in_dest[s*PW +: PW] = PW'(dsel[s]);
            in_cell[s*CW +: CW] = make_cell(s, dsel[s], tx_seq[s][dsel[s]]);
        end
        #1;
        acc_mask = vsel & in_ready;
        for (int s = 0; s < N; s++)
            if (acc_mask[s]) begin
                tx_seq[s][dsel[s]]++;
                tx_total++;
            end
    endtask

    // Monitor: content, destination and per-pair order of every delivered cell.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int j = 0; j < N; j++) begin
                if (out_valid[j] && out_ready[j]) begin
                    logic [CW-1:0] c;
                    int src;
                    c = out_cell[j*CW +: CW];
                    src = int'(c[23:16]) % N;
                    chk(int'(c[15:8]) == j, "R3 destination", int'(c[15:8]), j);
                    chk(c == make_cell(src, j, rx_seq[src][j]), "R6 order/R3 content",
                        int'(c[7:0]), rx_seq[src][j] % 256);
                    rx_seq[src][j]++;
                    rx_total++;
                    seen_src[j][src] = 1'b1;
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < N; a++) begin
            dsel[a] = 0;
            seen_src[a] = '0;
            for (int b = 0; b < N; b++) begin
                tx_seq[a][b] = 0;
                rx_seq[a][b] = 0;
            end
        end
        step(); step();
        rst_n = 1'b1;
        step();
        // R9: idle after reset
        chk(out_valid == '0, "R9 out_valid", int'(out_valid), 0);
        chk(in_ready == '1, "R9 in_ready", int'(in_ready), 15);

        // R3: every input-output pair alone, minimum latency
        for (int s = 0; s < N; s++)
            for (int d = 0; d < N; d++) begin
                vsel = '0; vsel[s] = 1'b1; dsel[s] = d;
                apply();
                chk(acc_mask[s], "R5 accept empty queue", int'(acc_mask[s]), 1);
                step();
                vsel = '0; apply();
                step();
                chk(out_valid == N'(1 << d), "R3 latency", int'(out_valid), 1 << d);
                step(); step();
            end

        // R8: permutations cross in one slot
        for (int r = 0; r < N + 1; r++) begin
            for (int s = 0; s < N; s++) dsel[s] = (r < N) ? (s + r) % N : N - 1 - s;
            vsel = '1; apply();
            step();
            vsel = '0; apply();
            step();
            chk(out_valid == '1, "R8 permutation", int'(out_valid), 15);
            step(); step();
        end

        // R7: all inputs to one output, served once each on consecutive cycles
        for (int d = 0; d < N; d++) begin
            seen_src[d] = '0;
            for (int s = 0; s < N; s++) dsel[s] = d;
            vsel = '1; apply();
            step();
            vsel = '0; apply();
            for (int c = 0; c < N; c++) begin
                step();
                chk(out_valid == N'(1 << d), "R7 one per cycle", int'(out_valid), 1 << d);
            end
            step();
            chk(out_valid == '0, "R7 drained", int'(out_valid), 0);
            chk(seen_src[d] == '1, "R7 every input served", int'(seen_src[d]), 15);
        end

        // R1/R4/R5: output 1 stalled, input 0 fills its path to it
        out_ready = 4'b1101;
        for (int c = 0; c < 8; c++) begin
            vsel = 4'b0001; dsel[0] = 1; apply();
            chk(acc_mask[0], "R5 accept until full", int'(acc_mask[0]), 1);
            step();
        end
        vsel = 4'b0001; dsel[0] = 1; apply();
        chk(!in_ready[0], "R5 refuse full queue", int'(in_ready[0]), 0);
        chk(acc_mask == '0, "R5 nothing taken", int'(acc_mask), 0);
        step();
        chk(out_valid[1], "R4 stalled output holds", int'(out_valid[1]), 1);
        vsel = 4'b0101; dsel[0] = 2; dsel[2] = 1; apply();
        chk(acc_mask == 4'b0101, "R1 other queues open", int'(acc_mask), 5);
        step();
        vsel = '0; apply();
        step();
        chk(out_valid[2], "R1 no head-of-line blocking", int'(out_valid[2]), 1);
        for (int c = 0; c < 4; c++) step();
        chk(rx_total == tx_total - 9, "R4 stalled cells retained", rx_total, tx_total - 9);
        out_ready = '1;
        for (int c = 0; c < 30; c++) step();
        chk(rx_total == tx_total, "R4 no loss after release", rx_total, tx_total);

        // R2/R4/R6: random traffic with random output stalls
        for (int c = 0; c < 3000; c++) begin
            vsel = N'($urandom);
            for (int s = 0; s < N; s++) dsel[s] = int'($urandom % N);
            out_ready = N'($urandom) | N'($urandom);
            apply();
            step();
        end
        vsel = '0; apply();
        out_ready = '1;
        for (int c = 0; c < 100; c++) step();
        chk(rx_total == tx_total, "R4 random totals", rx_total, tx_total);
        chk(out_valid == '0, "R4 all drained", int'(out_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule